// File: doc/BRIEF.md
# Timer Register Bus Slave

This block is the register front end of a general-purpose timer that sits on a 16-bit internal module bus. It matches a window of 64 bytes at a base address. It answers byte, word and long-word reads and writes in the same cycle they are presented, so there are no wait states. It also sets the access rights that apply to each location. A small set of control and status registers lives here. The counting datapath is outside the block and supplies its flags through plain status inputs.

The block drives the timer output pin. While the timer is stopped, a two-bit output-control field sets a fixed pin level or releases the pin. While the timer runs, the pin follows the datapath. On an interrupt-acknowledge cycle that the block has won, it returns the vector held in its vector register. If that vector was never programmed since reset, it flags a spurious outcome instead.

Register map (word offsets from the base): 0x00 CFG (bit 15 LOCK, reset 1), 0x02 IVR (bits 7:0 vector, reset 0x0F), 0x04 CTRL (bits 1:0 OC, bit 2 RUN), 0x06 STAT (read-only: 15:8 PO, 3 TO, 2 TC, 1 CMP, 0 PIN), 0x08 PRE (16-bit preload). Offsets 0x0A to 0x3E are reserved. The size code on `size` is 00 byte, 01 word and 10 long; 11 is treated as a word.

Top module: `tmr_bus_slave`

## Requirements
- R1: An access that hits the 64-byte window terminates in the cycle it is presented, with exactly one of `ack` or `berr` high. With `cyc` low, or with an address outside the window, both stay low and `rdata` is zero.
- R2: A word or byte read returns the 16-bit register of the containing word on `rdata[15:0]`, with the upper half zero. A long read returns the word at the address on `rdata[31:16]` and the word at address+2 on `rdata[15:0]`.
- R3: Reserved offsets read as zero, ignore writes, and accept user-mode accesses. This includes the second half of a long access at offset 0x3E, which falls past the end of the window.
- R4: Writes to STAT and to unused bits of CFG, IVR and CTRL are completed with `ack` but have no effect, and those unused bits read as zero. In a long write, each half follows this rule on its own.
- R5: A byte write carries its data on `wdata[7:0]`. It updates bits 15:8 when address bit 0 is 0, and bits 7:0 when address bit 0 is 1.
- R6: CFG and IVR are supervisor-only. A user access to them gives `berr` without `ack`, a zero `rdata`, and no register change.
- R7: CTRL, STAT and PRE are open to user mode only while CFG.LOCK is 0; otherwise the user access is refused as in R6. A long access is refused as a whole if either half is refused.
- R8: When `iack` and `iack_win` are both high and IVR has been written, `vec_valid` is high and `vec` carries IVR[7:0].
- R9: From reset until the first write that reaches IVR bits 7:0, a won acknowledge raises `spurious` and not `vec_valid`. A write that reaches only IVR bits 15:8 leaves this state unchanged. If `iack` or `iack_win` is low, both outputs stay low.
- R10: With RUN=0, OC selects the pin as follows: 00 releases it (`tout_oe`=0, `tout`=0), 01 drives 0, 10 drives 0, 11 drives 1. With RUN=1, `tout_oe`=1 and `tout` follows `tmr_lvl`.
- R11: With RUN=0, a STAT read shows TO, TC and CMP as 0 and PO as 0xFF. With RUN=1 it shows the status inputs.
- R12: STAT bit 0 always shows `pin_in`, the sensed level on the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc | input | 1 | Bus access present this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| size | input | 2 | 00 byte, 01 word, 10 long |
| addr | input | AW | Byte address |
| supv | input | 1 | 1 = supervisor access |
| wdata | input | 32 | Write data (long: high word first) |
| rdata | output | 32 | Read data |
| ack | output | 1 | Access completed normally |
| berr | output | 1 | Access refused by privilege |
| iack | input | 1 | Interrupt-acknowledge cycle |
| iack_win | input | 1 | This block won the acknowledge |
| vec | output | 8 | Supplied vector |
| vec_valid | output | 1 | Vector is being supplied |
| spurious | output | 1 | Acknowledge with unprogrammed vector |
| st_to | input | 1 | Timeout flag from datapath |
| st_tc | input | 1 | Terminal-count flag from datapath |
| st_cmp | input | 1 | Compare flag from datapath |
| st_po | input | 8 | Prescaler outputs from datapath |
| tmr_lvl | input | 1 | Output level from datapath while running |
| pin_in | input | 1 | Sensed level on the output pin |
| tout | output | 1 | Output pin value |
| tout_oe | output | 1 | Output pin drive enable |

## Verification
The hardest case to reach is a long access whose two halves fall under different rules. Examples are a read-only half next to a writable one, a reserved half beyond the window, and a refused half next to a permitted one. The bench reaches these by placing long accesses on every word boundary of interest, in both privilege modes and with LOCK in both states. It then reads each half back with single word reads to confirm that nothing leaked. The spurious-vector state exists only between reset and the first IVR write. It is reached by probing the acknowledge right after reset and again after a high-byte-only IVR write.

// File: rtl/tmr_pkg.sv
// Shared types and constants for the timer register slave.
// Assumes a 16-bit register file addressed in words within a small window.
package tmr_pkg;
    typedef enum logic [2:0] {
        RS_NONE,
        RS_CFG,
        RS_IVR,
        RS_CTRL,
        RS_STAT,
        RS_PRE
    } reg_sel_e;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_WORD = 2'b01;
    localparam logic [1:0] SZ_LONG = 2'b10;

    localparam int W_CFG  = 0;
    localparam int W_IVR  = 1;
    localparam int W_CTRL = 2;
    localparam int W_STAT = 3;
    localparam int W_PRE  = 4;

    localparam logic [7:0] IVR_RESET = 8'h0F;
endpackage

// File: rtl/tmr_decode.sv
// Word-offset decoder for one 16-bit half of an access.
// Input MSB set means the half lies past the window and is reserved.
// Outputs the selected register and whether the current privilege refuses it.
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W:0] widx,
    input  logic           supv,
    input  logic           lock,
    output reg_sel_e       sel,
    output logic           deny
);
    // Map the word index onto a register.
    always_comb begin
        sel = RS_NONE;
        if (!widx[IDX_W]) begin
            if      (widx[IDX_W-1:0] == IDX_W'(W_CFG))  sel = RS_CFG;
            else if (widx[IDX_W-1:0] == IDX_W'(W_IVR))  sel = RS_IVR;
            else if (widx[IDX_W-1:0] == IDX_W'(W_CTRL)) sel = RS_CTRL;
            else if (widx[IDX_W-1:0] == IDX_W'(W_STAT)) sel = RS_STAT;
            else if (widx[IDX_W-1:0] == IDX_W'(W_PRE))  sel = RS_PRE;
        end
    end

    // Privilege check: fixed supervisor set, plus the LOCK-gated set.
    always_comb begin
        deny = 1'b0;
        if (!supv) begin
            if (sel == RS_CFG || sel == RS_IVR)
                deny = 1'b1;
            else if (lock && (sel == RS_CTRL || sel == RS_STAT || sel == RS_PRE))
                deny = 1'b1;
        end
    end
endmodule

// File: rtl/tmr_regs.sv
// Register storage and read mux for the timer slave, serving two halves.
// Assumes the two halves of one access never select the same register.
module tmr_regs
    import tmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  wr_en,
    input  reg_sel_e    sel   [2],
    input  logic [1:0]  mask  [2],
    input  logic [15:0] wdat  [2],
    input  logic        st_to,
    input  logic        st_tc,
    input  logic        st_cmp,
    input  logic [7:0]  st_po,
    input  logic        pin_in,
    output logic [15:0] rdat  [2],
    output logic        lock,
    output logic [7:0]  ivr,
    output logic        ivr_set,
    output logic [1:0]  oc,
    output logic        run
);
    logic [15:0] pre;

    // Apply the writes of both halves, dropping read-only fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock    <= 1'b1;
            ivr     <= IVR_RESET;
            ivr_set <= 1'b0;
            oc      <= 2'b00;
            run     <= 1'b0;
            pre     <= 16'h0000;
        end else begin
            for (int h = 0; h < 2; h++) begin
                if (wr_en[h]) begin
                    case (sel[h])
                        RS_CFG:  if (mask[h][1]) lock <= wdat[h][15];
                        RS_IVR:  if (mask[h][0]) begin
                                     ivr     <= wdat[h][7:0];
                                     ivr_set <= 1'b1;
                                 end
                        RS_CTRL: if (mask[h][0]) begin
                                     oc  <= wdat[h][1:0];
                                     run <= wdat[h][2];
                                 end
                        RS_PRE:  begin
                                     if (mask[h][1]) pre[15:8] <= wdat[h][15:8];
                                     if (mask[h][0]) pre[7:0]  <= wdat[h][7:0];
                                 end
                        default: ;
                    endcase
                end
            end
        end
    end

    // Read mux per half; a stopped timer masks the datapath flags.
    always_comb begin
        for (int h = 0; h < 2; h++) begin
            case (sel[h])
                RS_CFG:  rdat[h] = {lock, 15'b0};
                RS_IVR:  rdat[h] = {8'h00, ivr};
                RS_CTRL: rdat[h] = {13'b0, run, oc};
                RS_STAT: rdat[h] = run ? {st_po, 4'b0, st_to, st_tc, st_cmp, pin_in}
                                       : {8'hFF, 7'b0, pin_in};
                RS_PRE:  rdat[h] = pre;
                default: rdat[h] = 16'h0000;
            endcase
        end
    end
endmodule

// File: rtl/tmr_outctl.sv
// Timer output pin driver. A stopped timer uses the two-bit static code;
// a running timer passes the datapath level through.
module tmr_outctl (
    input  logic [1:0] oc,
    input  logic       run,
    input  logic       tmr_lvl,
    output logic       tout,
    output logic       tout_oe
);
    // Select the pin level and drive enable.
    always_comb begin
        if (run) begin
            tout_oe = 1'b1;
            tout    = tmr_lvl;
        end else begin
            tout_oe = (oc != 2'b00);
            tout    = (oc == 2'b11);
        end
    end
endmodule

// File: rtl/tmr_bus_slave.sv
// Top of the timer register slave: window match, access sizing, privilege,
// zero-wait termination and interrupt-acknowledge vector supply.
// Assumes big-endian byte lanes and a window of 2**OFS_W bytes at BASE.
module tmr_bus_slave
    import tmr_pkg::*;
#(
    parameter int          AW    = 24,
    parameter int          OFS_W = 6,
    parameter logic [23:0] BASE  = 24'h000600
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc,
    input  logic          wr,
    input  logic [1:0]    size,
    input  logic [AW-1:0] addr,
    input  logic          supv,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    output logic          ack,
    output logic          berr,
    input  logic          iack,
    input  logic          iack_win,
    output logic [7:0]    vec,
    output logic          vec_valid,
    output logic          spurious,
    input  logic          st_to,
    input  logic          st_tc,
    input  logic          st_cmp,
    input  logic [7:0]    st_po,
    input  logic          tmr_lvl,
    input  logic          pin_in,
    output logic          tout,
    output logic          tout_oe
);
    localparam int IDX_W = OFS_W - 1;
    localparam logic [AW-1:0] BASE_A = AW'(BASE);

    logic           hit, is_long, is_byte, deny_any;
    logic [1:0]     act, hden, wr_en;
    logic [IDX_W:0] widx [2];
    reg_sel_e       hsel [2];
    logic [1:0]     mask [2];
    logic [15:0]    wdat [2];
    logic [15:0]    rdat [2];
    logic           lock, ivr_set, run;
    logic [7:0]     ivr;
    logic [1:0]     oc;

    // Window match and size decode.
    assign hit     = cyc && (addr[AW-1:OFS_W] == BASE_A[AW-1:OFS_W]);
    assign is_long = (size == SZ_LONG);
    assign is_byte = (size == SZ_BYTE);
    assign act     = {is_long, 1'b1};

    // Word indices of the two halves; a carry marks a half past the window.
    assign widx[0] = {1'b0, addr[OFS_W-1:1]};
    assign widx[1] = widx[0] + (IDX_W+1)'(1);

    for (genvar h = 0; h < 2; h++) begin : g_half
        tmr_decode #(.IDX_W(IDX_W)) u_dec (
            .widx (widx[h]),
            .supv (supv),
            .lock (lock),
            .sel  (hsel[h]),
            .deny (hden[h])
        );
    end

    // Termination: refusal of any active half refuses the whole access.
    assign deny_any = |(act & hden);
    assign berr     = hit && deny_any;
    assign ack      = hit && !deny_any;
    assign wr_en    = (ack && wr) ? act : 2'b00;

    // Byte lanes and write data per half.
    assign mask[0] = is_byte ? (addr[0] ? 2'b01 : 2'b10) : 2'b11;
    assign mask[1] = 2'b11;
    assign wdat[0] = is_long ? wdata[31:16]
                   : (is_byte ? {wdata[7:0], wdata[7:0]} : wdata[15:0]);
    assign wdat[1] = wdata[15:0];

    tmr_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .sel     (hsel),
        .mask    (mask),
        .wdat    (wdat),
        .st_to   (st_to),
        .st_tc   (st_tc),
        .st_cmp  (st_cmp),
        .st_po   (st_po),
        .pin_in  (pin_in),
        .rdat    (rdat),
        .lock    (lock),
        .ivr     (ivr),
        .ivr_set (ivr_set),
        .oc      (oc),
        .run     (run)
    );

    tmr_outctl u_out (
        .oc      (oc),
        .run     (run),
        .tmr_lvl (tmr_lvl),
        .tout    (tout),
        .tout_oe (tout_oe)
    );

    // Read data assembly: long puts the lower address in the high word.
    always_comb begin
        rdata = 32'h0;
        if (ack && !wr)
            rdata = is_long ? {rdat[0], rdat[1]} : {16'h0, rdat[0]};
    end

    // Interrupt acknowledge: vector if programmed, otherwise spurious.
    assign vec_valid = iack && iack_win && ivr_set;
    assign spurious  = iack && iack_win && !ivr_set;
    assign vec       = vec_valid ? ivr : 8'h00;
endmodule

// File: rtl/tmr_bus_chk.sv
// Property checker for tmr_bus_slave, observing its ports only.
module tmr_bus_chk #(
    parameter int AW    = 24,
    parameter int OFS_W = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cyc,
    input logic          wr,
    input logic [1:0]    size,
    input logic [AW-1:0] addr,
    input logic [31:0]   rdata,
    input logic          ack,
    input logic          berr,
    input logic          iack,
    input logic          iack_win,
    input logic          vec_valid,
    input logic          spurious,
    input logic          pin_in,
    input logic          tout,
    input logic          tout_oe
);
    logic seen_vec;

    // Remember that a vector has been supplied since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_vec <= 1'b0;
        else if (vec_valid) seen_vec <= 1'b1;
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc |-> (!ack && !berr && rdata == 32'h0));

    a_r6_berr_alone: assert property (@(posedge clk) disable iff (!rst_n)
        berr |-> (!ack && rdata == 32'h0));

    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wr && size != 2'b10 && addr[OFS_W-1:1] >= 5) |-> rdata == 32'h0);

    a_r12_pin_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wr && size != 2'b10 && addr[OFS_W-1:1] == 3) |-> rdata[0] == pin_in);

    a_r8_vec_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_valid && spurious));

    a_r9_need_won_iack: assert property (@(posedge clk) disable iff (!rst_n)
        !(iack && iack_win) |-> (!vec_valid && !spurious));

    a_r9_no_return_to_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_vec && iack && iack_win) |-> vec_valid);

    a_r6_refused_write_keeps_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (berr && wr) |=> $stable(tout_oe));

    a_r10_released_low: assert property (@(posedge clk) disable iff (!rst_n)
        !tout_oe |-> !tout);
endmodule

bind tmr_bus_slave tmr_bus_chk #(.AW(AW), .OFS_W(OFS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc       (cyc),
    .wr        (wr),
    .size      (size),
    .addr      (addr),
    .rdata     (rdata),
    .ack       (ack),
    .berr      (berr),
    .iack      (iack),
    .iack_win  (iack_win),
    .vec_valid (vec_valid),
    .spurious  (spurious),
    .pin_in    (pin_in),
    .tout      (tout),
    .tout_oe   (tout_oe)
);

// File: tb/sim_tmr_bus_slave.sv
module sim_tmr_bus_slave;
    localparam logic [23:0] BASE = 24'h000600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc = 1'b0, wr = 1'b0, supv = 1'b1;
    logic [1:0]  size = 2'b01;
    logic [23:0] addr = BASE;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        ack, berr;
    logic        iack = 1'b0, iack_win = 1'b0;
    logic [7:0]  vec;
    logic        vec_valid, spurious;
    logic        st_to = 1'b0, st_tc = 1'b0, st_cmp = 1'b0;
    logic [7:0]  st_po = 8'h00;
    logic        tmr_lvl = 1'b0, pin_in = 1'b1;
    logic        tout, tout_oe;

    int checks = 0;
    int errors = 0;

    // Bench copy of the programmed state, updated from the requirements.
    logic        m_lock = 1'b1;
    logic [7:0]  m_ivr = 8'h0F;
    logic [1:0]  m_oc = 2'b00;
    logic        m_run = 1'b0;
    logic [15:0] m_pre = 16'h0;

    logic [31:0] g_rd;
    logic        g_ack, g_berr;

    always #10 clk = ~clk;

    tmr_bus_slave #(.AW(24), .OFS_W(6), .BASE(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .cyc(cyc), .wr(wr), .size(size), .addr(addr),
        .supv(supv), .wdata(wdata), .rdata(rdata), .ack(ack), .berr(berr),
        .iack(iack), .iack_win(iack_win), .vec(vec), .vec_valid(vec_valid),
        .spurious(spurious), .st_to(st_to), .st_tc(st_tc), .st_cmp(st_cmp),
        .st_po(st_po), .tmr_lvl(tmr_lvl), .pin_in(pin_in), .tout(tout),
        .tout_oe(tout_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input int idx);
        case (idx)
            0: return {m_lock, 15'b0};
            1: return {8'h00, m_ivr};
            2: return {13'b0, m_run, m_oc};
            3: return m_run ? {st_po, 4'b0, st_to, st_tc, st_cmp, pin_in}
                            : {8'hFF, 7'b0, pin_in};
            4: return m_pre;
            default: return 16'h0;
        endcase
    endfunction

    // One bus cycle: drive at the falling edge, sample mid-phase, commit at rise.
    task automatic acc(input logic w, input logic [1:0] sz, input logic [5:0] ofs,
                       input logic sv, input logic [31:0] wd);
        @(negedge clk);
        cyc = 1'b1; wr = w; size = sz; addr = BASE | 24'(ofs); supv = sv; wdata = wd;
        #5;
        g_rd = rdata; g_ack = ack; g_berr = berr;
        @(posedge clk);
        #1 cyc = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_word(input string req, input int idx);
        acc(1'b0, 2'b01, 6'(idx * 2), 1'b1, 32'h0);
        chk(req, {g_ack, g_berr, g_rd}, {1'b1, 1'b0, 16'h0, exp_word(idx)});
    endtask

    task automatic probe_iack(input logic win);
        @(negedge clk);
        iack = 1'b1; iack_win = win;
        #5;
    endtask

    initial begin : watchdog
        #2000000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // Reset state of every word, supervisor reads (R2, R3, R11, R12).
        for (int i = 0; i < 32; i++) rd_word("R2 R3 reset read", i);

        // R1: outside window and idle give no termination.
        @(negedge clk);
        cyc = 1'b1; addr = BASE + 24'h40; size = 2'b01; #5;
        chk("R1 miss", {ack, berr, rdata}, 34'h0);
        cyc = 1'b0; #1;
        chk("R1 idle", {ack, berr}, 2'b00);

        // R9: spurious at reset; not without a win.
        probe_iack(1'b1);
        chk("R9 spurious after reset", {vec_valid, spurious}, 2'b01);
        iack_win = 1'b0; #1;
        chk("R9 no win", {vec_valid, spurious}, 2'b00);
        iack = 1'b0;
        // R9: high-byte-only IVR write keeps spurious.
        acc(1'b1, 2'b00, 6'h02, 1'b1, 32'h0000_0055);
        probe_iack(1'b1);
        chk("R9 high byte write", {vec_valid, spurious}, 2'b01);
        iack = 1'b0;

        // Word write sweep over all offsets then readback (R3, R4, R8).
        for (int i = 0; i < 32; i++) begin
            logic [15:0] p;
            p = 16'hA5C3 ^ 16'(i);
            acc(1'b1, 2'b01, 6'(i * 2), 1'b1, {16'h0, p});
            chk("R1 write ack", {g_ack, g_berr}, 2'b10);
            case (i)
                0: m_lock = p[15];
                1: m_ivr = p[7:0];
                2: begin m_oc = p[1:0]; m_run = p[2]; end
                4: m_pre = p;
                default: ;
            endcase
        end
        for (int i = 0; i < 32; i++) rd_word("R3 R4 readback", i);
        probe_iack(1'b1);
        chk("R8 vector", {vec_valid, spurious, vec}, {2'b10, m_ivr});
        iack = 1'b0;

        // R5: byte lanes on PRE.
        acc(1'b1, 2'b00, 6'h08, 1'b1, 32'h0000_0012); m_pre[15:8] = 8'h12;
        acc(1'b1, 2'b00, 6'h09, 1'b1, 32'h0000_0034); m_pre[7:0] = 8'h34;
        acc(1'b0, 2'b00, 6'h09, 1'b1, 32'h0);
        chk("R5 byte read", g_rd, 32'h0000_1234);

        // R2, R4: long accesses, per-half rules.
        acc(1'b0, 2'b10, 6'h02, 1'b1, 32'h0);
        chk("R2 long read", g_rd, {exp_word(1), exp_word(2)});
        acc(1'b1, 2'b10, 6'h04, 1'b1, 32'h0003_FFFF); m_oc = 2'b11; m_run = 1'b0;
        acc(1'b0, 2'b10, 6'h04, 1'b1, 32'h0);
        chk("R4 long write read-only half", g_rd, {exp_word(2), exp_word(3)});
        acc(1'b1, 2'b10, 6'h3E, 1'b1, 32'hFFFF_FFFF);
        acc(1'b0, 2'b10, 6'h3E, 1'b1, 32'h0);
        chk("R3 long past window", {g_ack, g_rd}, 33'h1_0000_0000);
        rd_word("R3 wrap did not hit CFG", 0);

        // R10: static output codes, then running follow.
        for (int c = 0; c < 4; c++) begin
            acc(1'b1, 2'b01, 6'h04, 1'b1, 32'(c)); m_oc = 2'(c); m_run = 1'b0;
            #2;
            chk("R10 static code", {tout_oe, tout}, {c != 0, c == 3});
        end
        st_to = 1'b1; st_cmp = 1'b1; st_po = 8'h5A;
        rd_word("R11 masked while stopped", 3);
        acc(1'b1, 2'b01, 6'h04, 1'b1, 32'h0000_0004); m_run = 1'b1; m_oc = 2'b00;
        for (int l = 0; l < 2; l++) begin
            tmr_lvl = l[0]; #2;
            chk("R10 running follow", {tout_oe, tout}, {1'b1, l[0]});
        end
        rd_word("R11 live while running", 3);
        pin_in = 1'b0;
        rd_word("R12 pin low", 3);
        pin_in = 1'b1;
        rd_word("R12 pin high", 3);

        // R6: user refused on supervisor-only registers.
        acc(1'b0, 2'b01, 6'h00, 1'b0, 32'h0);
        chk("R6 user CFG read", {g_ack, g_berr, g_rd}, 34'h1_0000_0000);
        acc(1'b1, 2'b01, 6'h02, 1'b0, 32'h0000_0077);
        chk("R6 user IVR write", {g_ack, g_berr}, 2'b01);
        rd_word("R6 IVR unchanged", 1);

        // R7: gated set, LOCK=1 then LOCK=0.
        acc(1'b1, 2'b01, 6'h00, 1'b1, 32'h0000_8000); m_lock = 1'b1;
        acc(1'b0, 2'b01, 6'h04, 1'b0, 32'h0);
        chk("R7 locked CTRL", {g_ack, g_berr}, 2'b01);
        acc(1'b1, 2'b01, 6'h08, 1'b0, 32'h0000_DEAD);
        rd_word("R7 locked PRE unchanged", 4);
        acc(1'b0, 2'b01, 6'h20, 1'b0, 32'h0);
        chk("R3 user reserved", {g_ack, g_berr, g_rd}, 34'h2_0000_0000);
        acc(1'b1, 2'b01, 6'h00, 1'b1, 32'h0000_0000); m_lock = 1'b0;
        acc(1'b1, 2'b01, 6'h08, 1'b0, 32'h0000_BEEF); m_pre = 16'hBEEF;
        chk("R7 unlocked PRE", {g_ack, g_berr}, 2'b10);
        rd_word("R7 PRE written", 4);
        acc(1'b1, 2'b10, 6'h02, 1'b0, 32'h0011_0003);
        chk("R7 long half refused", {g_ack, g_berr}, 2'b01);
        rd_word("R7 CTRL unchanged", 2);
        rd_word("R7 IVR unchanged", 1);
        acc(1'b0, 2'b10, 6'h06, 1'b0, 32'h0);
        chk("R7 user long allowed", {g_ack, g_rd}, {1'b1, exp_word(3), exp_word(4)});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule